// File: doc/BRIEF.md
# Slotted Deflection-Routing Cylinder Fabric

The fabric is a slot-synchronous switching network without internal storage. Node positions are laid out on nested rings. Each ring is a cylinder, and each position on it is named by a height and an angle. With H heights (a power of two) and A angles there are log2(H)+1 cylinders of H×A nodes each. Every clock edge is one slot. On each slot every packet in the fabric steps forward one angle. It either drops to the next inner cylinder at the same height, or stays on its own cylinder at a height chosen by the steering rule. A packet that cannot go inward keeps circling. It is never parked.

Packets enter at the outermost cylinder, one input per outer node. They leave at the innermost cylinder, one output per inner node. Each packet carries a destination height, a destination angle and a tag. For every input, the fabric shows a busy flag that tells the admission logic whether a circulating packet will claim that node on the next slot. A mode input selects one of two ejection rules. With the first, any inner node at the right height takes the packet. With the second, only the node at the exact height and angle takes it.

Top module: `vtx_fabric`

## Requirements
- R1: Out of reset the fabric is empty: every `out_valid` bit and every `in_busy` bit is 0.
- R2: Each valid packet advances exactly one angle per slot, from angle a to (a+1) mod A. In an otherwise empty fabric, a packet accepted at input index h0*A+a0 occupies an innermost node HB+m slots after the slot it was accepted in. Here HB=log2(H) and m is the number of bits that differ between h0 and its destination height. That node's angle is (a0+HB+m) mod A.
- R3: On cylinder c (0 = outermost), steering looks at height bit HB-1-c. A packet moves inward, keeping its height, only when that bit of its destination equals the same bit of the node's height and it is not blocked. Otherwise it stays on cylinder c and that height bit is inverted. Every packet on cylinder c therefore matches its destination in the top c height bits.
- R4: With `mode_exact`=0, an innermost node at height h ejects, in the same slot, any packet whose destination height is h. The node's angle does not matter. The packet appears on `out_valid`/`out_tag` at index h*A+angle.
- R5: With `mode_exact`=1, an innermost node ejects only a packet whose destination height and destination angle both equal its own. It appears at index dh*A+da. Any other packet moves on to the next angle at the same height.
- R6: When an inward move and a packet staying on the inner cylinder target the same node, the staying packet keeps the node. The outer packet is deflected along its own cylinder with the steering bit inverted. This adds at least two slots to its delivery.
- R7: `in_busy[h*A+a]` is 1 exactly when a packet staying on the outermost cylinder will occupy outer node (h,a) on the next slot. An input presented while its busy flag is 1 is discarded and never ejected. An input presented while its flag is 0 is accepted.
- R8: Every accepted packet is ejected exactly once, with its own tag. No packet is lost or duplicated under any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one slot per rising edge |
| rst | input | 1 | Synchronous reset, active high; empties the fabric |
| mode_exact | input | 1 | 0: eject on height only; 1: eject on height and angle |
| in_valid | input | H*A | Packet offered at outer node index h*A+a |
| in_dh | input | H*A*log2(H) | Destination height per input |
| in_da | input | H*A*log2(A) | Destination angle per input |
| in_tag | input | H*A*TW | Tag per input |
| in_busy | output | H*A | Outer node will be taken by a circulating packet next slot |
| out_valid | output | H*A | Packet ejected at innermost node index h*A+a this slot |
| out_tag | output | H*A*TW | Tag of the ejected packet, zero when not valid |

## Verification
Suppose a node takes a wrong steering decision or a wrong winner in a collision. The packet then arrives at the inner ring late or at the wrong angle. In an otherwise empty fabric this changes the exit slot or exit index within a few slots of injection, so the sweep over every input and destination pins the exact slot and index. A wrong busy flag, or a dropped or doubled packet at a collision, shows up in two places: as a missing tag, a repeated tag, or a tag that should have been discarded appearing at the outputs once a loaded run drains, and as a packet-count imbalance one slot after the fault.

// File: rtl/vtx_pkg.sv
`timescale 1ns/1ps
package vtx_pkg;

  typedef enum logic {
    EJ_HEIGHT = 1'b0,
    EJ_EXACT  = 1'b1
  } ej_mode_e;

  // height bit steered on cylinder c, most significant bit first
  function automatic int steer_bit(input int c, input int hb);
    return hb - 1 - c;
  endfunction

  // height after a stay move on cylinder c; innermost keeps its height
  function automatic int flip_h(input int h, input int c, input int hb);
    if (c >= hb) return h;
    return h ^ (1 << (hb - 1 - c));
  endfunction

  function automatic int next_ang(input int a, input int na);
    return (a + 1) % na;
  endfunction

  function automatic int prev_ang(input int a, input int na);
    return (a + na - 1) % na;
  endfunction

  function automatic int node_idx(input int c, input int h, input int a,
                                  input int nh, input int na);
    return (c * nh + h) * na + a;
  endfunction

endpackage

// File: rtl/vtx_hop.sv
`timescale 1ns/1ps
module vtx_hop
  import vtx_pkg::*;
#(
  parameter int HB  = 2,
  parameter int CYL = 0,
  parameter int HGT = 0
) (
  input  logic          vld,
  input  logic [HB-1:0] dst_h,
  input  logic          inner_busy,
  output logic          go_in,
  output logic          stay
);

  localparam int   SB       = steer_bit(CYL, HB);
  localparam logic NODE_BIT = 1'((HGT >> SB) & 1);

  logic aligned;
  logic enter_ok;

  assign aligned  = (dst_h[SB] == NODE_BIT);
  assign enter_ok = aligned & ~inner_busy;
  assign go_in    = vld & enter_ok;
  assign stay     = vld & ~enter_ok;

endmodule

// File: rtl/vtx_exit.sv
`timescale 1ns/1ps
module vtx_exit #(
  parameter int HB  = 2,
  parameter int AW  = 2,
  parameter int HGT = 0,
  parameter int ANG = 0
) (
  input  logic          vld,
  input  logic          mode_exact,
  input  logic [HB-1:0] dst_h,
  input  logic [AW-1:0] dst_a,
  output logic          eject,
  output logic          stay
);

  logic hit_h;
  logic hit_a;
  logic hit;

  assign hit_h = (dst_h == HB'(HGT));
  assign hit_a = (dst_a == AW'(ANG));
  assign hit   = hit_h & (~mode_exact | hit_a);
  assign eject = vld & hit;
  assign stay  = vld & ~hit;

endmodule

// File: rtl/vtx_fabric.sv
`timescale 1ns/1ps
module vtx_fabric
  import vtx_pkg::*;
#(
  parameter int H  = 4,
  parameter int A  = 4,
  parameter int TW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_exact,
  input  logic [H*A-1:0]             in_valid,
  input  logic [H*A*$clog2(H)-1:0]   in_dh,
  input  logic [H*A*$clog2(A)-1:0]   in_da,
  input  logic [H*A*TW-1:0]          in_tag,
  output logic [H*A-1:0]             in_busy,
  output logic [H*A-1:0]             out_valid,
  output logic [H*A*TW-1:0]          out_tag
);

  localparam int HB = $clog2(H);
  localparam int AW = $clog2(A);
  localparam int C  = HB + 1;
  localparam int N  = H * A;
  localparam int NN = C * N;

  // node state
  logic          v_q  [C][H][A];
  logic [HB-1:0] dh_q [C][H][A];
  logic [AW-1:0] da_q [C][H][A];
  logic [TW-1:0] tg_q [C][H][A];

  logic          v_d  [C][H][A];
  logic [HB-1:0] dh_d [C][H][A];
  logic [AW-1:0] da_d [C][H][A];
  logic [TW-1:0] tg_d [C][H][A];

  // per-node move decisions
  logic stay_w [C][H][A];
  logic go_w   [C][H][A];
  logic blk_w  [C][H][A];

  // named events for the checker
  logic [NN-1:0]    occ_w;
  logic [NN*HB-1:0] all_dh_w;
  logic [NN*AW-1:0] all_da_w;
  logic [N-1:0]     acc_w;
  logic [N-1:0]     ej_w;

  assign acc_w = in_valid & ~in_busy;

  for (genvar c = 0; c < C; c++) begin : g_cyl
    for (genvar h = 0; h < H; h++) begin : g_row
      for (genvar a = 0; a < A; a++) begin : g_col
        localparam int K = node_idx(c, h, a, H, A);

        assign occ_w[K]                = v_q[c][h][a];
        assign all_dh_w[K*HB +: HB]    = dh_q[c][h][a];
        assign all_da_w[K*AW +: AW]    = da_q[c][h][a];

        if (c < HB) begin : g_hop
          localparam int IH = flip_h(h, c + 1, HB);
          // the inner node reached by going inward from here is also
          // reached by the stay move of inner node (c+1, IH, a)
          assign blk_w[c][h][a] = stay_w[c+1][IH][a];

          vtx_hop #(
            .HB (HB),
            .CYL(c),
            .HGT(h)
          ) u_hop (
            .vld       (v_q[c][h][a]),
            .dst_h     (dh_q[c][h][a]),
            .inner_busy(blk_w[c][h][a]),
            .go_in     (go_w[c][h][a]),
            .stay      (stay_w[c][h][a])
          );
        end else begin : g_exit
          assign blk_w[c][h][a] = 1'b0;
          assign go_w[c][h][a]  = 1'b0;

          vtx_exit #(
            .HB (HB),
            .AW (AW),
            .HGT(h),
            .ANG(a)
          ) u_exit (
            .vld       (v_q[c][h][a]),
            .mode_exact(mode_exact),
            .dst_h     (dh_q[c][h][a]),
            .dst_a     (da_q[c][h][a]),
            .eject     (ej_w[h*A+a]),
            .stay      (stay_w[c][h][a])
          );

          assign out_valid[h*A+a]          = ej_w[h*A+a];
          assign out_tag[(h*A+a)*TW +: TW] = ej_w[h*A+a] ? tg_q[c][h][a] : '0;
        end

        if (c == 0) begin : g_busy
          localparam int SH = flip_h(h, 0, HB);
          localparam int PA = prev_ang(a, A);
          assign in_busy[h*A+a] = stay_w[0][SH][PA];
        end
      end
    end
  end

  // slot move: stay beats inward beats injection (only one can be present
  // when busy gates injection and blocking gates inward moves)
  always_comb begin
    int sh;
    int pa;
    int n;
    for (int c = 0; c < C; c++) begin
      for (int h = 0; h < H; h++) begin
        for (int a = 0; a < A; a++) begin
          sh = flip_h(h, c, HB);
          pa = prev_ang(a, A);
          n  = h * A + a;
          v_d[c][h][a]  = 1'b0;
          dh_d[c][h][a] = '0;
          da_d[c][h][a] = '0;
          tg_d[c][h][a] = '0;
          if (stay_w[c][sh][pa]) begin
            v_d[c][h][a]  = 1'b1;
            dh_d[c][h][a] = dh_q[c][sh][pa];
            da_d[c][h][a] = da_q[c][sh][pa];
            tg_d[c][h][a] = tg_q[c][sh][pa];
          end else if (c > 0 && go_w[(c > 0) ? c - 1 : 0][h][pa]) begin
            v_d[c][h][a]  = 1'b1;
            dh_d[c][h][a] = dh_q[(c > 0) ? c - 1 : 0][h][pa];
            da_d[c][h][a] = da_q[(c > 0) ? c - 1 : 0][h][pa];
            tg_d[c][h][a] = tg_q[(c > 0) ? c - 1 : 0][h][pa];
          end else if (c == 0 && acc_w[n]) begin
            v_d[c][h][a]  = 1'b1;
            dh_d[c][h][a] = in_dh[n*HB +: HB];
            da_d[c][h][a] = in_da[n*AW +: AW];
            tg_d[c][h][a] = in_tag[n*TW +: TW];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < C; c++) begin
      for (int h = 0; h < H; h++) begin
        for (int a = 0; a < A; a++) begin
          if (rst) v_q[c][h][a] <= 1'b0;
          else     v_q[c][h][a] <= v_d[c][h][a];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < C; c++) begin
      for (int h = 0; h < H; h++) begin
        for (int a = 0; a < A; a++) begin
          dh_q[c][h][a] <= dh_d[c][h][a];
          da_q[c][h][a] <= da_d[c][h][a];
          tg_q[c][h][a] <= tg_d[c][h][a];
        end
      end
    end
  end

endmodule

// File: rtl/vtx_fabric_chk.sv
`timescale 1ns/1ps
module vtx_fabric_chk #(
  parameter int H = 4,
  parameter int A = 4
) (
  input logic                                         clk,
  input logic                                         rst,
  input logic                                         mode_exact,
  input logic [($clog2(H)+1)*H*A-1:0]                 occ_w,
  input logic [($clog2(H)+1)*H*A*$clog2(H)-1:0]       all_dh_w,
  input logic [($clog2(H)+1)*H*A*$clog2(A)-1:0]       all_da_w,
  input logic [H*A-1:0]                               acc_w,
  input logic [H*A-1:0]                               ej_w,
  input logic [H*A-1:0]                               in_busy
);

  localparam int HB = $clog2(H);
  localparam int AW = $clog2(A);
  localparam int N  = H * A;

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R8: population changes only by acceptances and ejections
  a_r8_conserve: assert property (@(posedge clk) disable iff (rst)
    seen |-> ($countones(occ_w) ==
              $past($countones(occ_w)) - $past($countones(ej_w)) + $past($countones(acc_w))));

  for (genvar n = 0; n < N; n++) begin : g_io
    localparam int NH = n / A;
    localparam int NA = n % A;
    localparam int KI = HB * N + n;

    // R7: a busy input is taken by a circulating packet next slot
    a_r7_busy_fills: assert property (@(posedge clk) disable iff (rst)
      in_busy[n] |=> occ_w[n]);

    // R4 / R5: ejection only at the addressed inner node
    a_r5_eject_addr: assert property (@(posedge clk) disable iff (rst)
      ej_w[n] |-> (all_dh_w[KI*HB +: HB] == HB'(NH)) &&
                  (!mode_exact || all_da_w[KI*AW +: AW] == AW'(NA)));

    // R4: in height mode no packet lingers on the inner ring
    a_r4_height_leaves: assert property (@(posedge clk) disable iff (rst)
      (!mode_exact && occ_w[KI]) |-> ej_w[n]);
  end

  // R3: a packet on cylinder c already matches its top c height bits
  for (genvar c = 1; c <= HB; c++) begin : g_pre_c
    for (genvar h = 0; h < H; h++) begin : g_pre_h
      for (genvar a = 0; a < A; a++) begin : g_pre_a
        localparam int K = (c * H + h) * A + a;
        localparam logic [HB-1:0] HV = HB'(h);
        a_r3_prefix: assert property (@(posedge clk) disable iff (rst)
          occ_w[K] |-> ((all_dh_w[K*HB +: HB] >> (HB - c)) == (HV >> (HB - c))));
      end
    end
  end

endmodule

bind vtx_fabric vtx_fabric_chk #(.H(H), .A(A)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_exact(mode_exact),
  .occ_w     (occ_w),
  .all_dh_w  (all_dh_w),
  .all_da_w  (all_da_w),
  .acc_w     (acc_w),
  .ej_w      (ej_w),
  .in_busy   (in_busy)
);

// File: tb/test_vtx_fabric.sv
`timescale 1ns/1ps
module test_vtx_fabric;

  localparam int H  = 4;
  localparam int A  = 4;
  localparam int TW = 8;
  localparam int HB = 2;
  localparam int AW = 2;
  localparam int N  = H * A;
  localparam int LIVE_MAX = 200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_exact = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*HB-1:0]   in_dh = '0;
  logic [N*AW-1:0]   in_da = '0;
  logic [N*TW-1:0]   in_tag = '0;
  logic [N-1:0]      in_busy;
  logic [N-1:0]      out_valid;
  logic [N*TW-1:0]   out_tag;

  vtx_fabric #(.H(H), .A(A), .TW(TW)) i_vtx_fabric (
    .clk       (clk),
    .rst       (rst),
    .mode_exact(mode_exact),
    .in_valid  (in_valid),
    .in_dh     (in_dh),
    .in_da     (in_da),
    .in_tag    (in_tag),
    .in_busy   (in_busy),
    .out_valid (out_valid),
    .out_tag   (out_tag)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int tnow = 0;
  int seen_cnt [256];
  int seen_t   [256];
  int seen_n   [256];
  int exp_dh   [256];
  int exp_da   [256];

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 256; i++) begin
      seen_cnt[i] = 0; seen_t[i] = -1; seen_n[i] = -1;
    end
    tnow = 0;
  endtask

  task automatic scan();
    for (int n = 0; n < N; n++) begin
      if (out_valid[n]) begin
        int tg;
        tg = int'(out_tag[n*TW +: TW]);
        seen_cnt[tg]++;
        if (seen_cnt[tg] == 1) begin
          seen_t[tg] = tnow; seen_n[tg] = n;
        end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tnow++;
    scan();
  endtask

  task automatic offer(input int n, input int dh, input int da, input int tg);
    in_valid[n]          = 1'b1;
    in_dh[n*HB +: HB]    = HB'(dh);
    in_da[n*AW +: AW]    = AW'(da);
    in_tag[n*TW +: TW]   = TW'(tg);
  endtask

  // one packet alone in the fabric, exit slot and index from R2/R4/R5
  task automatic single(input bit mx, input int sh, input int sa, input int dh, input int da);
    int m, tin, ain, texp, nexp;
    m    = $countones(sh ^ dh);
    tin  = 1 + HB + m;
    ain  = (sa + HB + m) % A;
    if (mx) begin
      texp = tin + ((da - ain + A) % A);
      nexp = dh * A + da;
    end else begin
      texp = tin;
      nexp = dh * A + ain;
    end
    clear_seen();
    mode_exact = mx;
    in_valid = '0;
    offer(sh * A + sa, dh, da, 9);
    step();
    in_valid = '0;
    repeat (11) step();
    check(seen_cnt[9] == 1 && seen_t[9] == texp,
          mx ? "R5 exit slot exact mode" : "R2 exit slot height mode", seen_t[9], texp);
    check(seen_n[9] == nexp,
          mx ? "R5 exit index exact mode" : "R4 exit index height mode", seen_n[9], nexp);
  endtask

  task automatic load(input bit mx);
    int live_n, drop_n, dropped_seen;
    live_n = 0; drop_n = 0; dropped_seen = 0;
    clear_seen();
    mode_exact = mx;
    for (int cyc = 0; cyc < 600 && live_n < LIVE_MAX; cyc++) begin
      in_valid = '0;
      for (int n = 0; n < N; n++) begin
        if (($urandom % 3) == 0 && live_n < LIVE_MAX) begin
          int dh, da;
          dh = int'($urandom % H);
          da = int'($urandom % A);
          if (in_busy[n]) begin
            offer(n, dh, da, LIVE_MAX + (drop_n % 56));
            drop_n++;
          end else begin
            exp_dh[live_n] = dh;
            exp_da[live_n] = da;
            offer(n, dh, da, live_n);
            live_n++;
          end
        end
      end
      step();
    end
    in_valid = '0;
    repeat (200) step();
    for (int tg = 0; tg < live_n; tg++) begin
      int en;
      check(seen_cnt[tg] == 1, "R8 delivered exactly once", seen_cnt[tg], 1);
      if (mx) begin
        en = exp_dh[tg] * A + exp_da[tg];
        check(seen_n[tg] == en, "R5 loaded exit index", seen_n[tg], en);
      end else begin
        en = exp_dh[tg];
        check(seen_n[tg] / A == en, "R4 loaded exit height", seen_n[tg] / A, en);
      end
    end
    for (int tg = LIVE_MAX; tg < 256; tg++) dropped_seen += seen_cnt[tg];
    check(dropped_seen == 0, "R7 busy offers discarded", dropped_seen, 0);
    check(out_valid == '0, "R8 fabric drained", int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tnow, 0);
    summary();
  end

  initial begin
    clear_seen();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_busy == '0, "R1 in_busy after reset", int'(in_busy), 0);

    // R2 R4 R5: every input to every destination, both modes
    for (int mx = 0; mx < 2; mx++)
      for (int s = 0; s < N; s++)
        for (int d = 0; d < N; d++)
          single(mx[0], s / A, s % A, d / A, d % A);

    // R7: busy flag and discard; tag 3 from (0,0) to height 2 stays on
    // cylinder 0 and lands on outer node (2,1) = index 9
    clear_seen();
    mode_exact = 1'b0;
    in_valid = '0;
    offer(0, 2, 0, 3);
    step();
    in_valid = '0;
    check(in_busy == N'(1 << 9), "R7 busy marks index 9 only", int'(in_busy), 1 << 9);
    offer(9, 0, 0, 250);
    offer(5, 1, 0, 7);
    step();
    in_valid = '0;
    repeat (12) step();
    check(seen_cnt[250] == 0, "R7 busy offer discarded", seen_cnt[250], 0);
    check(seen_cnt[7] == 1 && seen_t[7] == 4, "R7 free offer accepted", seen_t[7], 4);
    check(seen_n[7] == 7, "R7 free offer index", seen_n[7], 7);
    check(seen_cnt[3] == 1 && seen_t[3] == 4, "R3 flipped packet slot", seen_t[3], 4);
    check(seen_n[3] == 11, "R3 flipped packet index", seen_n[3], 11);

    // R6: exact mode, tag 1 circles the inner ring at height 0 and
    // blocks tag 2 twice; tag 2 would exit at slot 4 unblocked
    clear_seen();
    mode_exact = 1'b1;
    in_valid = '0;
    offer(0, 0, 1, 1);
    step();
    in_valid = '0;
    offer(1, 0, 3, 2);
    step();
    in_valid = '0;
    repeat (12) step();
    check(seen_cnt[1] == 1 && seen_t[1] == 6, "R6 circulating packet slot", seen_t[1], 6);
    check(seen_n[1] == 1, "R6 circulating packet index", seen_n[1], 1);
    check(seen_cnt[2] == 1 && seen_t[2] == 8, "R6 deflected packet slot", seen_t[2], 8);
    check(seen_n[2] == 3, "R6 deflected packet index", seen_n[2], 3);

    // same offers in height mode: nothing circulates, no deflection
    clear_seen();
    mode_exact = 1'b0;
    offer(0, 0, 1, 1);
    step();
    in_valid = '0;
    offer(1, 0, 3, 2);
    step();
    in_valid = '0;
    repeat (12) step();
    check(seen_t[1] == 3 && seen_n[1] == 2, "R4 height mode first exit", seen_t[1], 3);
    check(seen_t[2] == 4 && seen_n[2] == 3, "R6 no block in height mode", seen_t[2], 4);

    // R8 under random load in both modes
    load(1'b0);
    load(1'b1);

    summary();
  end

endmodule